// File: doc/BRIEF.md
# Dual-Channel Address Breakpoint Controller

This block watches the bus cycles a processor issues. For each of two identical channels it compares the cycle's address against a programmed break address. Part of the address can be left out of the compare. The match is also qualified by the bus master and the access kind. When a cycle qualifies, the channel sets a sticky match flag in the cycle after the bus cycle. This is early enough for an instruction-fetch break to be raised before the fetched instruction runs.

Each channel drives its own interrupt request line to an external priority controller. The line is high while the flag is set and the channel's interrupt enable is on. Software programs the channels through a small register window and polls or clears the flags there. Only a write of 0 to the flag bit clears it. For a fetch break, software programs the address of the first byte of the instruction.

Top module: `brk_watch`

## Requirements
- R1: After reset every register reads as zero and both `brk_irq` bits are 0.
- R2: The register window is selected by `reg_sel`. Bit 0 picks the control register (1) or the address register (0), and the upper bits pick the channel (0 for A, 1 for B). Control layout, the same for both channels: bit 7 match flag, bit 6 master select, bits 5:3 mask count, bits 2:1 condition, bit 0 interrupt enable. Control reads return 0 in bits above 7, and the address register reads back what was written.
- R3: A mask count of n leaves the n lowest address bits out of the compare. A count of 0 compares every bit, and 7 ignores seven bits.
- R4: Condition 00 matches only instruction fetches (`mon_kind` 00) by the CPU (`mon_master` 0), and only while the master select is 0. `mon_kind` 11 never matches.
- R5: Condition 01 matches reads (`mon_kind` 01), 10 matches writes (`mon_kind` 10) and 11 matches either. A data match also needs `mon_master` to equal the master select.
- R6: A qualifying cycle with `mon_valid` high sets that channel's flag, which is visible from the next clock cycle. The interrupt enable does not affect this.
- R7: Writing the control register with bit 7 at 0 clears the flag, and writing 1 leaves it unchanged. If a clearing write and a match fall in the same cycle, the flag stays set.
- R8: `brk_irq` for a channel equals its flag AND its enable. It holds until one of the two is cleared, and it rises when the enable is set while the flag is already set.
- R9: The channels are independent. A match or a register write on one channel leaves the other channel's flag and request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: bit 0 is control/address, bit 1 is the channel |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data for the selected register (combinational) |
| mon_valid | input | 1 | A bus cycle is present this clock |
| mon_addr | input | 24 | Bus cycle address |
| mon_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 none |
| mon_master | input | 1 | 0 CPU, 1 other master |
| brk_irq | output | 2 | Break requests, bit 0 channel A, bit 1 channel B |

## Verification
A wrong compare or a wrong qualification term shows up one clock after the offending bus cycle. It appears as a flag in the control readback and, with the enable on, as a request edge. The bench checks both right after each stimulated cycle. A flag that clears wrongly or is lost against a same-cycle write shows up on the next read of the control register. The bench reads it after every write. Cross-talk between channels is caught by always checking both request bits together.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_NONE  = 2'b11
  } bus_kind_e;

  // Control register image; bit order is fixed because software decodes it.
  typedef struct packed {
    logic       flag;    // [7]
    logic       master;  // [6]
    logic [2:0] mask;    // [5:3]
    logic [1:0] cond;    // [2:1]
    logic       ien;     // [0]
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int CMP_W  = 32;

  // True when two addresses agree once the lowest n bits are dropped.
  function automatic logic addr_agrees(input logic [CMP_W-1:0] a,
                                       input logic [CMP_W-1:0] b,
                                       input logic [2:0]       n);
    logic [CMP_W-1:0] diff;
    diff = (a ^ b) >> n;
    return (diff == '0);
  endfunction

  // True when the access kind and master satisfy a condition field.
  function automatic logic cond_accepts(input logic [1:0] cond,
                                        input logic       msel,
                                        input bus_kind_e  kind,
                                        input logic       master);
    logic kind_ok;
    if (cond == 2'b00) begin
      return (kind == KIND_FETCH) && !master && !msel;
    end
    kind_ok = ((kind == KIND_READ) && cond[0]) || ((kind == KIND_WRITE) && cond[1]);
    return kind_ok && (master == msel);
  endfunction

endpackage

// File: rtl/brk_compare.sv
module brk_compare
  import brk_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_valid,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic [1:0]        mon_kind,
  input  logic              mon_master,
  input  logic [ADDR_W-1:0] base,
  input  ctrl_t             ctrl,
  output logic              hit
);

  logic addr_hit;
  logic qual_hit;

  always_comb begin
    addr_hit = addr_agrees(CMP_W'(mon_addr), CMP_W'(base), ctrl.mask);
    qual_hit = cond_accepts(ctrl.cond, ctrl.master, bus_kind_e'(mon_kind), mon_master);
    hit      = mon_valid && addr_hit && qual_hit;
  end

  AST_FETCH_ONLY_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctrl.cond == 2'b00) |-> (mon_kind == 2'b00 && !mon_master && !ctrl.master)); // R4

  AST_DATA_MASTER_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctrl.cond != 2'b00) |-> (mon_master == ctrl.master && mon_kind != 2'b11)); // R5

endmodule

// File: rtl/brk_channel.sv
module brk_channel
  import brk_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic              ctrl_we,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              mon_valid,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic [1:0]        mon_kind,
  input  logic              mon_master,
  output logic [ADDR_W-1:0] base_q,
  output ctrl_t             ctrl_q,
  output logic              irq
);

  ctrl_t wr_img;
  logic  hit;
  logic  flag_clr;
  logic  flag_d;

  assign wr_img   = ctrl_t'(wdata[CTRL_W-1:0]);
  assign flag_clr = ctrl_we && !wr_img.flag;

  brk_compare #(.ADDR_W(ADDR_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_valid (mon_valid),
    .mon_addr  (mon_addr),
    .mon_kind  (mon_kind),
    .mon_master(mon_master),
    .base      (base_q),
    .ctrl      (ctrl_q),
    .hit       (hit)
  );

  // A match in the same cycle as a clearing write wins.
  always_comb begin
    if (hit)           flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = ctrl_q.flag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (addr_we) base_q <= wdata;
      if (ctrl_we) begin
        ctrl_q.master <= wr_img.master;
        ctrl_q.mask   <= wr_img.mask;
        ctrl_q.cond   <= wr_img.cond;
        ctrl_q.ien    <= wr_img.ien;
      end
      ctrl_q.flag <= flag_d;
    end
  end

  assign irq = ctrl_q.flag && ctrl_q.ien;

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ctrl_q.flag); // R6

  AST_FLAG_ONLY_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q.flag) |-> $past(ctrl_we && !wdata[7] && !hit)); // R7

  AST_IRQ_DROP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(ctrl_we)); // R8

endmodule

// File: rtl/brk_watch.sv
module brk_watch
  import brk_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NCH    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              mon_valid,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic [1:0]        mon_kind,
  input  logic              mon_master,
  output logic [NCH-1:0]    brk_irq
);

  localparam int SEL_W = $clog2(2 * NCH);
  localparam int IDX_W = (SEL_W > 1) ? SEL_W - 1 : 1;

  logic [ADDR_W-1:0] base_arr [NCH];
  ctrl_t             ctrl_arr [NCH];
  logic [IDX_W-1:0]  rd_idx;

  assign rd_idx = IDX_W'(reg_sel >> 1);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_me;
    assign sel_me = (IDX_W'(c) == rd_idx);

    brk_channel #(.ADDR_W(ADDR_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_we   (reg_we && sel_me && !reg_sel[0]),
      .ctrl_we   (reg_we && sel_me &&  reg_sel[0]),
      .wdata     (reg_wdata),
      .mon_valid (mon_valid),
      .mon_addr  (mon_addr),
      .mon_kind  (mon_kind),
      .mon_master(mon_master),
      .base_q    (base_arr[c]),
      .ctrl_q    (ctrl_arr[c]),
      .irq       (brk_irq[c])
    );
  end

  always_comb begin
    if (reg_sel[0]) reg_rdata = ADDR_W'(ctrl_arr[rd_idx]);
    else            reg_rdata = base_arr[rd_idx];
  end

  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel[0] |-> (reg_rdata[ADDR_W-1:CTRL_W] == '0)); // R2

  AST_CH_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel[1]) |=> $stable(ctrl_arr[0].flag) || $past(mon_valid)); // R9

endmodule

// File: tb/brk_watch_tb.sv
module brk_watch_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        mon_valid = 1'b0;
  logic [23:0] mon_addr = '0;
  logic [1:0]  mon_kind = 2'b11;
  logic        mon_master = 1'b0;
  logic [1:0]  brk_irq;

  always #2 clk = ~clk;

  brk_watch u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_valid(mon_valid),
    .mon_addr(mon_addr), .mon_kind(mon_kind), .mon_master(mon_master),
    .brk_irq(brk_irq)
  );

  typedef struct {
    bit          is_irq;
    logic [23:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  event  push_ev;
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  logic [23:0] m_base [2];
  logic [7:0]  m_ctrl [2];

  function automatic bit m_hit(int ch, logic [23:0] a, logic [1:0] k, bit mst);
    logic [7:0] c;
    bit near;
    c = m_ctrl[ch];
    near = ((a ^ m_base[ch]) >> c[5:3]) == 24'd0;
    if (c[2:1] == 2'b00) return near && k == 2'b00 && !mst && !c[6];
    return near && (mst == c[6]) && ((k == 2'b01 && c[1]) || (k == 2'b10 && c[2]));
  endfunction

  function automatic void m_write(int sel, logic [23:0] d);
    int ch;
    ch = sel / 2;
    if (sel % 2 == 0) m_base[ch] = d;
    else m_ctrl[ch] = {m_ctrl[ch][7] & d[7], d[6:0]};
  endfunction

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      @(push_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [23:0] act;
        it = sb.pop_front();
        act = it.is_irq ? {22'd0, brk_irq} : reg_rdata;
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic do_wr(int sel, logic [23:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'(sel); reg_wdata = d;
    m_write(sel, d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic do_bus(logic [23:0] a, logic [1:0] k, bit mst);
    @(negedge clk);
    mon_valid = 1'b1; mon_addr = a; mon_kind = k; mon_master = mst;
    for (int ch = 0; ch < 2; ch++) if (m_hit(ch, a, k, mst)) m_ctrl[ch][7] = 1'b1;
    @(negedge clk);
    mon_valid = 1'b0; mon_kind = 2'b11;
  endtask

  task automatic do_both(int sel, logic [23:0] d, logic [23:0] a, logic [1:0] k, bit mst);
    bit h [2];
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'(sel); reg_wdata = d;
    mon_valid = 1'b1; mon_addr = a; mon_kind = k; mon_master = mst;
    for (int ch = 0; ch < 2; ch++) h[ch] = m_hit(ch, a, k, mst);
    m_write(sel, d);
    for (int ch = 0; ch < 2; ch++) if (h[ch]) m_ctrl[ch][7] = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; mon_valid = 1'b0; mon_kind = 2'b11;
  endtask

  task automatic chk_rd(int sel, string tag);
    item_t it;
    @(negedge clk);
    reg_sel = 2'(sel);
    #1;
    it.is_irq = 1'b0;
    it.exp = (sel % 2) ? {16'd0, m_ctrl[sel / 2]} : m_base[sel / 2];
    it.tag = tag;
    sb.push_back(it);
    -> push_ev;
  endtask

  task automatic chk_irq(string tag);
    item_t it;
    @(negedge clk);
    #1;
    it.is_irq = 1'b1;
    it.exp = {22'd0, m_ctrl[1][7] & m_ctrl[1][0], m_ctrl[0][7] & m_ctrl[0][0]};
    it.tag = tag;
    sb.push_back(it);
    -> push_ev;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int ch = 0; ch < 2; ch++) begin m_base[ch] = '0; m_ctrl[ch] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int s = 0; s < 4; s++) chk_rd(s, "R1 reset readback");
    chk_irq("R1 reset irq");

    // Channel A: exact fetch break.
    do_wr(0, 24'h001234);
    do_wr(1, 24'hFFFF01);
    chk_rd(0, "R2 addr A readback");
    chk_rd(1, "R2 ctrl A readback upper zero");
    do_bus(24'h001235, 2'b00, 1'b0);
    chk_irq("R3 exact compare off by one");
    do_bus(24'h001234, 2'b00, 1'b1);
    chk_irq("R4 fetch by non-CPU master");
    do_bus(24'h001234, 2'b11, 1'b0);
    chk_irq("R4 kind 11 never matches");
    do_bus(24'h001234, 2'b00, 1'b0);
    chk_rd(1, "R6 flag set after fetch");
    chk_irq("R8 irq A raised");

    // Writing 1 to the flag keeps it; writing 0 clears it.
    do_wr(1, 24'h000081);
    chk_rd(1, "R7 write 1 keeps flag");
    chk_irq("R8 irq held");
    do_wr(1, 24'h000001);
    chk_rd(1, "R7 write 0 clears flag");
    chk_irq("R8 irq drops with flag");

    // Fetch condition with master select 1 never matches.
    do_wr(1, 24'h000041);
    do_bus(24'h001234, 2'b00, 1'b0);
    chk_rd(1, "R4 fetch needs master select 0");

    // Channel B: write break, mask 3, other master.
    do_wr(2, 24'h00A000);
    do_wr(3, 24'h00005D);
    chk_rd(3, "R2 ctrl B layout");
    do_bus(24'h00A005, 2'b01, 1'b1);
    chk_irq("R5 read ignored by write condition");
    do_bus(24'h00A007, 2'b10, 1'b0);
    chk_irq("R5 wrong master");
    do_bus(24'h00A008, 2'b10, 1'b1);
    chk_irq("R3 bit above mask compared");
    do_bus(24'h00A007, 2'b10, 1'b1);
    chk_irq("R9 only channel B requests");
    chk_rd(1, "R9 channel A flag untouched");

    // Enable off: flag sets, no request; enable on later raises it.
    do_wr(1, 24'h000006);
    do_bus(24'h001234, 2'b01, 1'b0);
    chk_rd(1, "R6 flag sets with enable off");
    chk_irq("R8 no irq with enable off");
    do_wr(1, 24'h000087);
    chk_irq("R8 irq rises on enable");
    do_wr(1, 24'h000087 & 24'h00007F);
    do_wr(3, 24'h00001D);
    chk_irq("R9 clears are per channel");

    // Mask 7 on channel A, read condition.
    do_wr(1, 24'h00003B);
    do_bus(24'h001280, 2'b01, 1'b0);
    chk_irq("R3 mask 7 bit 7 still compared");
    do_bus(24'h00127F, 2'b01, 1'b0);
    chk_irq("R3 mask 7 ignores low bits");

    // Same-cycle clear and match: match wins.
    do_both(1, 24'h00003B, 24'h001200, 2'b01, 1'b0);
    chk_rd(1, "R7 match beats clear");
    chk_irq("R7 irq stays on collision");

    // Read-or-write condition.
    do_wr(1, 24'h000007);
    do_bus(24'h001234, 2'b10, 1'b0);
    chk_rd(1, "R5 condition 11 takes writes");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule